// File: doc/BRIEF.md
# CAN Error Confinement and Bus-Off Recovery Controller

This block keeps the transmit and receive error counts of one CAN node and runs the error-warning, bus-off and recovery sequence. The protocol engine sends it counter adjust events, each with a direction and an amount. An external idle detector sends one pulse for every bus-idle interval it sees. Software supplies a warning level and can write a request that clears the init flag.

On the outputs, the block reports the warning and bus-off flags, the init flag and both counters. It also gives three single-cycle interrupt pulses: warning, bus-off and alert.

In normal operation the transmit count is held with one extra bit, so an overflow past 255 can be seen before it wraps. Any adjust that would take the transmit count past 255 puts the node into bus-off. From that point the receive counter no longer counts errors. It counts idle intervals instead, which measures how far recovery has progressed. When it reaches the warning level, the block issues a warning and a bus-off pulse together as an early sign that recovery is almost done. After the 128th idle interval the node leaves bus-off and raises an alert. The init flag stays set until software clears it.

Top module: `can_busoff_ctrl`

## Requirements
- R1: While rst_n is low, and after it is released, the outputs are: tec_o = 0, rec_o = 0, warn_o = 0, boff_o = 0, init_o = 1, and all interrupt outputs 0. Every output is registered, so an input sampled at clock edge k shows up on the outputs just after edge k.
- R2: Outside bus-off, an event on tx_evt_i or rx_evt_i changes its counter by the matching amount. The counter goes up when the dn input is 0 and down when it is 1. A decrement stops at 0. The receive count saturates at 255.
- R3: Outside bus-off, warn_o is 1 exactly when tec_o or rec_o is at least warn_lvl_i. irq_warn_o pulses for one cycle when warn_o goes from 0 to 1. warn_o returns to 0 once both counts are below the level.
- R4: An event that would take the transmit count above 255 enters bus-off in that cycle. The result is tec_o = 1, rec_o = 1, boff_o = 1, warn_o = 0, init_o = 1 and one irq_boff_o pulse. An init-clear request in the same cycle is lost.
- R5: While boff_o = 1, adjust events and init-clear requests have no effect. Each idle_pulse_i adds 1 to rec_o, and tec_o stays at 1.
- R6: During bus-off, the idle pulse that brings rec_o up to warn_lvl_i sets warn_o. In that same cycle both irq_warn_o and irq_boff_o pulse.
- R7: The 128th idle pulse after bus-off entry (seen when rec_o = 128) clears boff_o and warn_o and sets tec_o = rec_o = 0. It also gives one irq_alert_o pulse, and init_o stays 1.
- R8: init_clr_i clears init_o only outside bus-off. An idle_pulse_i outside bus-off has no effect.
- R9: Each interrupt output is high for a single cycle only, and does not pulse again while its condition still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_evt_i | input | 1 | Transmit counter adjust event |
| tx_dn_i | input | 1 | Direction of the transmit adjust: 1 = decrement |
| tx_amt_i | input | AMT_W | Amount of the transmit adjust |
| rx_evt_i | input | 1 | Receive counter adjust event |
| rx_dn_i | input | 1 | Direction of the receive adjust: 1 = decrement |
| rx_amt_i | input | AMT_W | Amount of the receive adjust |
| idle_pulse_i | input | 1 | One pulse per detected bus-idle interval |
| warn_lvl_i | input | CNT_W | Programmable warning level |
| init_clr_i | input | 1 | Software request to clear the init flag |
| warn_o | output | 1 | Error-warning flag |
| boff_o | output | 1 | Bus-off flag |
| init_o | output | 1 | Init flag |
| tec_o | output | CNT_W | Transmit error count |
| rec_o | output | CNT_W | Receive error count, or the recovery count during bus-off |
| irq_warn_o | output | 1 | Warning interrupt pulse |
| irq_boff_o | output | 1 | Bus-off interrupt pulse |
| irq_alert_o | output | 1 | Alert interrupt pulse (recovery complete) |

## Verification
Two actions can land in the same cycle: entering bus-off and a software request to clear init. The bench provokes this by sending the transmit increment that passes 255 while init_clr_i is high. It then expects init_o = 1 along with the bus-off pulse. A second collision is an idle pulse arriving together with adjust events during recovery. Here the bench expects only the idle count to move. A scoreboard queue compares every cycle's outputs, including all three interrupt pulses, against values derived from the requirements.

// File: rtl/can_bo_pkg.sv
package can_bo_pkg;
  typedef enum logic {
    MODE_ACTIVE = 1'b0,
    MODE_OFF    = 1'b1
  } bo_mode_e;
endpackage

// File: rtl/can_bo_ctr.sv
module can_bo_ctr #(
  parameter int W     = 8,
  parameter int AMT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             dn,
  input  logic [AMT_W-1:0] amt,
  input  logic             inc1,
  input  logic             ld,
  input  logic [W-1:0]     ld_val,
  output logic [W-1:0]     q,
  output logic [W-1:0]     arith
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W:0]   wide;
  logic [W:0]   ext;
  logic [W:0]   sum;
  logic [W-1:0] d;
  logic         en;

  always_comb begin
    wide  = {1'b0, q};
    ext   = (W+1)'(amt);
    sum   = '0;
    arith = q;
    if (evt) begin
      if (dn) begin
        arith = (ext > wide) ? '0 : W'(wide - ext);
      end else begin
        sum   = wide + ext;
        arith = sum[W] ? MAXV : sum[W-1:0];
      end
    end else if (inc1) begin
      sum   = wide + (W+1)'(1);
      arith = sum[W] ? MAXV : sum[W-1:0];
    end
  end

  always_comb begin
    en = ld | evt | inc1;
    d  = ld ? ld_val : arith;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

  // R4
  ld_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (q == $past(ld_val)));

  // R2
  dn_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && dn && !ld && (W'(amt) >= q)) |=> (q == '0));
endmodule

// File: rtl/can_bo_thr.sv
module can_bo_thr #(
  parameter int A_W = 9,
  parameter int B_W = 8,
  parameter int L_W = 8
) (
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  input  logic [L_W-1:0] lvl,
  output logic           hit
);
  localparam int CW = (A_W > B_W) ? ((A_W > L_W) ? A_W : L_W)
                                  : ((B_W > L_W) ? B_W : L_W);
  logic [CW-1:0] a_x, b_x, l_x;

  always_comb begin
    a_x = CW'(a);
    b_x = CW'(b);
    l_x = CW'(lvl);
    hit = (a_x >= l_x) || (b_x >= l_x);
  end
endmodule

// File: rtl/can_bo_seq.sv
module can_bo_seq
  import can_bo_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int TEC_W  = 9,
  parameter int RECOV  = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_evt,
  input  logic             rx_evt,
  input  logic             idle,
  input  logic             clr_req,
  input  logic [CNT_W-1:0] lvl,
  input  logic [TEC_W-1:0] tec_arith,
  input  logic [CNT_W-1:0] rec_q,
  input  logic [CNT_W-1:0] rec_arith,
  input  logic             thr_hit,
  output logic             tx_evt_g,
  output logic             rx_evt_g,
  output logic             idle_g,
  output logic             cnt_ld,
  output logic [TEC_W-1:0] tec_ld_val,
  output logic [CNT_W-1:0] rec_ld_val,
  output logic             warn_q,
  output logic             boff,
  output logic             init_q,
  output logic             irq_w_q,
  output logic             irq_b_q,
  output logic             irq_a_q
);
  localparam logic [TEC_W-1:0] TEC_LIM   = TEC_W'((1 << CNT_W) - 1);
  localparam logic [CNT_W-1:0] RECOV_CNT = CNT_W'(RECOV);

  bo_mode_e mode_q, mode_d;
  logic     warn_d, init_d, iw_d, ib_d, ia_d;
  logic     enter, done, pre;

  always_comb begin
    boff     = (mode_q == MODE_OFF);
    tx_evt_g = tx_evt & ~boff;
    rx_evt_g = rx_evt & ~boff;
    enter    = ~boff & (tec_arith > TEC_LIM);
    done     = boff & idle & (rec_q == RECOV_CNT);
    idle_g   = boff & idle & ~done;
    pre      = idle_g & ~warn_q & (rec_arith >= lvl);
    cnt_ld   = enter | done;
    tec_ld_val = enter ? TEC_W'(1) : '0;
    rec_ld_val = enter ? CNT_W'(1) : '0;
  end

  always_comb begin
    mode_d = mode_q;
    warn_d = warn_q;
    init_d = init_q;
    iw_d   = 1'b0;
    ib_d   = 1'b0;
    ia_d   = 1'b0;
    if (!boff) begin
      if (enter) begin
        mode_d = MODE_OFF;
        warn_d = 1'b0;
        init_d = 1'b1;
        ib_d   = 1'b1;
      end else begin
        warn_d = thr_hit;
        iw_d   = thr_hit & ~warn_q;
        if (clr_req) init_d = 1'b0;
      end
    end else if (done) begin
      mode_d = MODE_ACTIVE;
      warn_d = 1'b0;
      ia_d   = 1'b1;
    end else if (pre) begin
      warn_d = 1'b1;
      iw_d   = 1'b1;
      ib_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_ACTIVE;
      warn_q  <= 1'b0;
      init_q  <= 1'b1;
      irq_w_q <= 1'b0;
      irq_b_q <= 1'b0;
      irq_a_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      warn_q  <= warn_d;
      init_q  <= init_d;
      irq_w_q <= iw_d;
      irq_b_q <= ib_d;
      irq_a_q <= ia_d;
    end
  end

  // R9
  warn_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_w_q |=> !irq_w_q);
  // R9
  boff_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_b_q |=> !irq_b_q);
  // R9
  alert_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a_q |=> !irq_a_q);
  // R6
  prewarn_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_w_q && boff) |-> (irq_b_q && warn_q));
  // R7
  alert_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a_q |-> (!boff && !warn_q && init_q));
  // R8
  init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boff |-> init_q);
endmodule

// File: rtl/can_busoff_ctrl.sv
module can_busoff_ctrl #(
  parameter int CNT_W = 8,
  parameter int AMT_W = 4,
  parameter int RECOV = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_evt_i,
  input  logic             tx_dn_i,
  input  logic [AMT_W-1:0] tx_amt_i,
  input  logic             rx_evt_i,
  input  logic             rx_dn_i,
  input  logic [AMT_W-1:0] rx_amt_i,
  input  logic             idle_pulse_i,
  input  logic [CNT_W-1:0] warn_lvl_i,
  input  logic             init_clr_i,
  output logic             warn_o,
  output logic             boff_o,
  output logic             init_o,
  output logic [CNT_W-1:0] tec_o,
  output logic [CNT_W-1:0] rec_o,
  output logic             irq_warn_o,
  output logic             irq_boff_o,
  output logic             irq_alert_o
);
  localparam int TEC_W = CNT_W + 1;

  logic             tx_evt_g, rx_evt_g, idle_g, cnt_ld, thr_hit;
  logic [TEC_W-1:0] tec_q, tec_arith, tec_ld_val;
  logic [CNT_W-1:0] rec_q, rec_arith, rec_ld_val;

  can_bo_ctr #(.W(TEC_W), .AMT_W(AMT_W)) u_tec (
    .clk(clk), .rst_n(rst_n), .evt(tx_evt_g), .dn(tx_dn_i), .amt(tx_amt_i),
    .inc1(1'b0), .ld(cnt_ld), .ld_val(tec_ld_val), .q(tec_q), .arith(tec_arith)
  );

  can_bo_ctr #(.W(CNT_W), .AMT_W(AMT_W)) u_rec (
    .clk(clk), .rst_n(rst_n), .evt(rx_evt_g), .dn(rx_dn_i), .amt(rx_amt_i),
    .inc1(idle_g), .ld(cnt_ld), .ld_val(rec_ld_val), .q(rec_q), .arith(rec_arith)
  );

  can_bo_thr #(.A_W(TEC_W), .B_W(CNT_W), .L_W(CNT_W)) u_thr (
    .a(tec_arith), .b(rec_arith), .lvl(warn_lvl_i), .hit(thr_hit)
  );

  can_bo_seq #(.CNT_W(CNT_W), .TEC_W(TEC_W), .RECOV(RECOV)) u_seq (
    .clk(clk), .rst_n(rst_n), .tx_evt(tx_evt_i), .rx_evt(rx_evt_i),
    .idle(idle_pulse_i), .clr_req(init_clr_i), .lvl(warn_lvl_i),
    .tec_arith(tec_arith), .rec_q(rec_q), .rec_arith(rec_arith), .thr_hit(thr_hit),
    .tx_evt_g(tx_evt_g), .rx_evt_g(rx_evt_g), .idle_g(idle_g), .cnt_ld(cnt_ld),
    .tec_ld_val(tec_ld_val), .rec_ld_val(rec_ld_val), .warn_q(warn_o),
    .boff(boff_o), .init_q(init_o), .irq_w_q(irq_warn_o), .irq_b_q(irq_boff_o),
    .irq_a_q(irq_alert_o)
  );

  assign tec_o = tec_q[CNT_W-1:0];
  assign rec_o = rec_q;

  // R4
  tec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tec_q[TEC_W-1]);
  // R4
  boff_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boff_o) |-> (tec_q == TEC_W'(1) && rec_q == CNT_W'(1) && init_o && irq_boff_o));
  // R5
  boff_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boff_o && !idle_pulse_i) |=> ($stable(tec_q) && $stable(rec_q)));
  // R7
  alert_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_alert_o |-> (tec_q == '0 && rec_q == '0));
endmodule

// File: tb/can_busoff_ctrl_tb.sv
module can_busoff_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_evt, tx_dn, rx_evt, rx_dn, idle, clr;
  logic [3:0] tx_amt, rx_amt;
  logic [7:0] lvl;
  logic       warn_o, boff_o, init_o, iw_o, ib_o, ia_o;
  logic [7:0] tec_o, rec_o;

  always #5ns clk = ~clk;

  can_busoff_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .tx_evt_i(tx_evt), .tx_dn_i(tx_dn), .tx_amt_i(tx_amt),
    .rx_evt_i(rx_evt), .rx_dn_i(rx_dn), .rx_amt_i(rx_amt), .idle_pulse_i(idle),
    .warn_lvl_i(lvl), .init_clr_i(clr), .warn_o(warn_o), .boff_o(boff_o),
    .init_o(init_o), .tec_o(tec_o), .rec_o(rec_o), .irq_warn_o(iw_o),
    .irq_boff_o(ib_o), .irq_alert_o(ia_o)
  );

  typedef struct {
    int    tec, rec;
    bit    w, b, i, iw, ib, ia;
    string tag;
  } exp_t;

  exp_t q[$];
  int   total = 0, bad = 0;
  bit   fin = 0;
  int   et = 0, er = 0;
  bit   ew = 0, eb = 0, ei = 1;

  task automatic push(bit iw, bit ib, bit ia, string tag);
    exp_t e;
    e.tec = et; e.rec = er; e.w = ew; e.b = eb; e.i = ei;
    e.iw = iw; e.ib = ib; e.ia = ia; e.tag = tag;
    q.push_back(e);
  endtask

  // drive one cycle at the falling edge, push the expectation, clear inputs
  task automatic cyc(bit te, bit td, int ta, bit re, bit rd, int ra,
                     bit idl, bit c, string tag);
    int  nt, nr;
    bit  nw, iw, ib, ia;
    iw = 0; ib = 0; ia = 0;
    tx_evt = te; tx_dn = td; tx_amt = 4'(ta);
    rx_evt = re; rx_dn = rd; rx_amt = 4'(ra);
    idle = idl; clr = c;
    if (!eb) begin
      nt = et; nr = er;
      if (te) nt = td ? ((ta > nt) ? 0 : nt - ta) : nt + ta;
      if (re) nr = rd ? ((ra > nr) ? 0 : nr - ra) : ((nr + ra > 255) ? 255 : nr + ra);
      if (nt > 255) begin
        et = 1; er = 1; eb = 1; ew = 0; ei = 1; ib = 1;
      end else begin
        et = nt; er = nr;
        nw = (et >= int'(lvl)) || (er >= int'(lvl));
        iw = nw && !ew; ew = nw;
        if (c) ei = 0;
      end
    end else if (idl) begin
      if (er == 128) begin
        et = 0; er = 0; eb = 0; ew = 0; ia = 1;
      end else begin
        er = er + 1;
        if (!ew && er >= int'(lvl)) begin ew = 1; iw = 1; ib = 1; end
      end
    end
    push(iw, ib, ia, tag);
    @(posedge clk);
    @(negedge clk);
    tx_evt = 0; rx_evt = 0; idle = 0; clr = 0;
  endtask

  task automatic chk(string tag, string f, int act, int ex);
    if (act != ex) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, f, act, ex);
    end
  endtask

  // monitor: pops one expectation per clock and compares
  initial begin
    forever begin
      @(posedge clk);
      #2ns;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        chk(e.tag, "tec", int'(tec_o), e.tec);
        chk(e.tag, "rec", int'(rec_o), e.rec);
        chk(e.tag, "warn", int'(warn_o), int'(e.w));
        chk(e.tag, "boff", int'(boff_o), int'(e.b));
        chk(e.tag, "init", int'(init_o), int'(e.i));
        chk(e.tag, "irq_warn", int'(iw_o), int'(e.iw));
        chk(e.tag, "irq_boff", int'(ib_o), int'(e.ib));
        chk(e.tag, "irq_alert", int'(ia_o), int'(e.ia));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic recover(string tag);
    for (int k = 0; k < 128; k++)
      cyc(k % 3 == 0, 0, 9, k % 5 == 0, 0, 7, 1, k % 7 == 0, tag);
  endtask

  initial begin
    rst_n = 0; tx_evt = 0; tx_dn = 0; tx_amt = 0; rx_evt = 0; rx_dn = 0;
    rx_amt = 0; idle = 0; clr = 0; lvl = 8'h60;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R1");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, "R8_clr");
    cyc(0, 0, 0, 0, 0, 0, 1, 0, "R8_idle_normal");
    // R3 warning via transmit count
    for (int k = 0; k < 13; k++) cyc(1, 0, 8, 0, 0, 0, 0, 0, "R3_tx_up");
    cyc(1, 1, 8, 0, 0, 0, 0, 0, "R3_tx_dn");
    cyc(1, 1, 8, 0, 0, 0, 0, 0, "R3_clear");
    // R2 receive saturation and warning via receive count
    for (int k = 0; k < 18; k++) cyc(0, 0, 0, 1, 0, 15, 0, 0, "R2_rx_sat");
    for (int k = 0; k < 19; k++) cyc(0, 0, 0, 1, 1, 15, 0, 0, "R2_rx_floor");
    for (int k = 0; k < 7; k++) cyc(1, 1, 15, 0, 0, 0, 0, 0, "R2_tx_floor");
    // R4 bus-off entry colliding with init clear
    for (int k = 0; k < 17; k++) cyc(1, 0, 15, 1, 0, 3, 0, 0, "R4_fill");
    cyc(1, 0, 1, 0, 0, 0, 0, 1, "R4_entry_vs_clr");
    // R5 events and clears ignored in bus-off
    for (int k = 0; k < 4; k++) cyc(1, k[0], 15, 1, 0, 15, 0, 1, "R5_ignored");
    // R6 pre-warning and R7 completion
    recover("R6_R7_recover");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R9_after_alert");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, "R8_clr_after");
    // second run with a lower level
    lvl = 8'h20;
    for (int k = 0; k < 18; k++) cyc(1, 0, 15, 0, 0, 0, 0, 0, "R3_low_lvl");
    recover("R6_low_lvl");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R7_end");
    @(posedge clk); @(negedge clk);
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule